// File: doc/BRIEF.md
# Reset and Power-Down Pin Controller

This block sits between the chip's reset-related pins and the core. It qualifies two active-low pins against the machine-cycle strobe. The first is a plain reset pin. The second is a power-down pin that gives a reset for a short low pulse and hardware power-down for a long one. The block merges these pin events with two internal fault events: a watchdog timeout and an oscillator failure. From them it produces one internal reset request and an active-low reset output, both stretched past the release of the last source. While hardware power-down is active, the block also drives a pin-float flag.

A third pin acts as a power-save enable and chooses the watchdog start behaviour. While it is low, software requests for power-down, idle and slow-down pass through as grants. While it is high, those requests are blocked. The level of this pin during reset decides whether a watchdog start pulse is issued when reset ends. A fourth pin enables the oscillator-failure reset source.

All four pins go through a two-flop synchronizer. The machine-cycle strobe is a one-clock pulse, once per machine cycle (twelve oscillator periods in normal use). A power-on reset input `por_n` initialises the block.

Top module: `rpd_ctrl`

## Requirements
- R1: A reset is raised (`rst_out_n` low, `rst_req` high) once the synchronized `rst_pin_n` has been seen low at QUAL_MC (2) consecutive strobes. A low seen at only one strobe raises no reset.
- R2: The synchronized `pd_pin_n` low at QUAL_MC strobes, but fewer than PD_LONG_MC (4), raises a reset without `pins_float`. One strobe low raises neither.
- R3: The synchronized `pd_pin_n` low at PD_LONG_MC strobes sets `pins_float`, with reset asserted throughout. `pins_float` clears within three clocks of the pin returning high. `rst_pin_n` never sets `pins_float`, however long it is low.
- R4: After every reset source has cleared, `rst_out_n` stays low until the (HOLD_MC+1)-th strobe. With HOLD_MC=2 it is still low after the second strobe and high after the third. This guarantees at least HOLD_MC full machine cycles. Leaving power-down therefore always ends in such a stretched reset.
- R5: A one-clock `wdt_timeout` pulse raises a reset on the following clock.
- R6: `osc_wd_en` follows the synchronized `owe_pin`. An `osc_fail` pulse raises a reset only while it is high.
- R7: `grant_pd`, `grant_idle` and `grant_slow` follow their requests while the synchronized `pe_swd_pin` is low, and are 0 while it is high.
- R8: When reset ends, `wdt_start` pulses high for exactly one clock if `pe_swd_pin` was high during the reset. If the pin was low during the reset, there is no pulse.
- R9: While `por_n` is low and until the third strobe after its release, `rst_out_n` is 0 and `pins_float` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| mc_stb | input | 1 | One-clock strobe per machine cycle |
| rst_pin_n | input | 1 | External reset pin, active low |
| pd_pin_n | input | 1 | Power-down pin, active low |
| pe_swd_pin | input | 1 | Power-save enable / watchdog start select pin |
| owe_pin | input | 1 | Oscillator watchdog enable pin |
| wdt_timeout | input | 1 | Watchdog timeout event |
| osc_fail | input | 1 | Oscillator failure event |
| sw_pd_req | input | 1 | Software power-down request |
| sw_idle_req | input | 1 | Software idle request |
| sw_slow_req | input | 1 | Software slow-down request |
| rst_req | output | 1 | Internal reset request, active high |
| rst_out_n | output | 1 | Reset output, active low |
| pins_float | output | 1 | Hardware power-down active, pins float |
| osc_wd_en | output | 1 | Oscillator watchdog enabled |
| wdt_start | output | 1 | One-clock watchdog auto-start pulse |
| grant_pd | output | 1 | Power-down request granted |
| grant_idle | output | 1 | Idle request granted |
| grant_slow | output | 1 | Slow-down request granted |

## Verification
The assertions assume that `mc_stb` is a single-clock pulse spaced several clocks apart, wider than the synchronizer delay. They also assume that the fault inputs are synchronous to `clk`. The bench produces the strobe from a free-running divide-by-twelve counter and moves every pin one falling clock edge after a strobe. Each pin edge therefore reaches the counters well before the next strobe, and low durations are counted in whole strobes. Fault events are single-clock pulses driven on falling edges.

// File: rtl/rpd_pkg.sv
package rpd_pkg;

  typedef struct packed {
    logic pin;
    logic pd;
    logic wdt;
    logic osc;
  } rst_src_t;

  // saturating increment used by the low-time counters
  function automatic int unsigned sat_inc(int unsigned v, int unsigned lim);
    return (v < lim) ? v + 1 : v;
  endfunction

  // threshold test on a low-time count
  function automatic logic reached(int unsigned cnt, int unsigned lim);
    return cnt >= lim;
  endfunction

  // strobes loaded into the stretch counter for a hold of hold_mc full cycles
  function automatic int unsigned hold_load(int unsigned hold_mc);
    return hold_mc + 1;
  endfunction

endpackage

// File: rtl/rpd_sync.sv
module rpd_sync #(
  parameter int          W      = 1,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] INIT  = '1
) (
  input  logic         clk,
  input  logic         por_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= INIT;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/rpd_lowcnt.sv
module rpd_lowcnt #(
  parameter int LIMIT = 4,
  localparam int CW   = $clog2(LIMIT + 1)
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          mc_stb,
  input  logic          low,
  output logic [CW-1:0] cnt
);
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)      cnt <= '0;
    else if (!low)   cnt <= '0;
    else if (mc_stb) cnt <= CW'(rpd_pkg::sat_inc(int'(cnt), LIMIT));
  end

  // R1 a nonzero count needs the pin low on the previous clock
  // R1
  cnt_low_chk: assert property (@(posedge clk) disable iff (!por_n)
    (cnt != '0) |-> $past(low));
endmodule

// File: rtl/rpd_stretch.sv
module rpd_stretch #(
  parameter int HOLD_MC = 2,
  localparam int LOAD   = rpd_pkg::hold_load(HOLD_MC),
  localparam int HW     = $clog2(LOAD + 1)
) (
  input  logic clk,
  input  logic por_n,
  input  logic mc_stb,
  input  logic src_any,
  output logic active
);
  logic [HW-1:0] hold;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                    hold <= HW'(LOAD);
    else if (src_any)              hold <= HW'(LOAD);
    else if (mc_stb && hold != '0) hold <= hold - 1'b1;
  end

  assign active = (hold != '0);

  // R5
  src_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
    src_any |=> active);

  // R4
  rel_strobe_chk: assert property (@(posedge clk) disable iff (!por_n)
    $fell(active) |-> $past(mc_stb) && !$past(src_any));
endmodule

// File: rtl/rpd_ctrl.sv
module rpd_ctrl #(
  parameter int QUAL_MC    = 2,
  parameter int PD_LONG_MC = 4,
  parameter int HOLD_MC    = 2,
  localparam int CW        = $clog2(PD_LONG_MC + 1)
) (
  input  logic clk,
  input  logic por_n,
  input  logic mc_stb,
  input  logic rst_pin_n,
  input  logic pd_pin_n,
  input  logic pe_swd_pin,
  input  logic owe_pin,
  input  logic wdt_timeout,
  input  logic osc_fail,
  input  logic sw_pd_req,
  input  logic sw_idle_req,
  input  logic sw_slow_req,
  output logic rst_req,
  output logic rst_out_n,
  output logic pins_float,
  output logic osc_wd_en,
  output logic wdt_start,
  output logic grant_pd,
  output logic grant_idle,
  output logic grant_slow
);
  import rpd_pkg::*;

  // synchronized pins: {owe, pe, pd_n, rst_n}
  logic [3:0] pins_s;
  rpd_sync #(.W(4), .STAGES(2), .INIT(4'hF)) u_sync (
    .clk(clk), .por_n(por_n),
    .d({owe_pin, pe_swd_pin, pd_pin_n, rst_pin_n}), .q(pins_s)
  );

  logic owe_s, pe_s;
  logic [1:0] pin_low;
  assign pin_low = {~pins_s[1], ~pins_s[0]};
  assign pe_s    = pins_s[2];
  assign owe_s   = pins_s[3];

  // low-time counters, index 0 reset pin, index 1 power-down pin
  logic [CW-1:0] low_cnt [2];
  logic [1:0]    q_short;
  for (genvar g = 0; g < 2; g++) begin : g_qual
    rpd_lowcnt #(.LIMIT(PD_LONG_MC)) u_cnt (
      .clk(clk), .por_n(por_n), .mc_stb(mc_stb),
      .low(pin_low[g]), .cnt(low_cnt[g])
    );
    assign q_short[g] = reached(int'(low_cnt[g]), QUAL_MC);
  end

  logic pd_long;
  assign pd_long = reached(int'(low_cnt[1]), PD_LONG_MC);

  // hardware power-down state, left only when the pin is high again
  logic pd_state;
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)          pd_state <= 1'b0;
    else if (!pin_low[1]) pd_state <= 1'b0;
    else if (pd_long)    pd_state <= 1'b1;
  end

  rst_src_t src;
  logic     src_any;
  assign src.pin = q_short[0];
  assign src.pd  = q_short[1] | pd_state;
  assign src.wdt = wdt_timeout;
  assign src.osc = osc_fail & owe_s;
  assign src_any = |src;

  logic active;
  rpd_stretch #(.HOLD_MC(HOLD_MC)) u_stretch (
    .clk(clk), .por_n(por_n), .mc_stb(mc_stb),
    .src_any(src_any), .active(active)
  );

  // watchdog start select sampled during reset
  logic pe_lat, act_prev;
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      pe_lat   <= 1'b0;
      act_prev <= 1'b1;
    end else begin
      if (active) pe_lat <= pe_s;
      act_prev <= active;
    end
  end

  assign wdt_start  = act_prev & ~active & pe_lat;
  assign rst_req    = active;
  assign rst_out_n  = ~active;
  assign pins_float = pd_state;
  assign osc_wd_en  = owe_s;
  assign grant_pd   = sw_pd_req   & ~pe_s;
  assign grant_idle = sw_idle_req & ~pe_s;
  assign grant_slow = sw_slow_req & ~pe_s;

  // R3
  float_rst_chk: assert property (@(posedge clk) disable iff (!por_n)
    pd_state |-> active);

  // R8
  start_once_chk: assert property (@(posedge clk) disable iff (!por_n)
    wdt_start |=> !wdt_start && !active);
endmodule

// File: tb/rpd_ctrl_tb_top.sv
module rpd_ctrl_tb_top;
  localparam int HOLD = 2;

  logic clk = 1'b0;
  logic por_n = 1'b0, mc_stb = 1'b0;
  logic rst_pin_n = 1'b1, pd_pin_n = 1'b1, pe_swd_pin = 1'b1, owe_pin = 1'b1;
  logic wdt_timeout = 1'b0, osc_fail = 1'b0;
  logic sw_pd_req = 1'b0, sw_idle_req = 1'b0, sw_slow_req = 1'b0;
  logic rst_req, rst_out_n, pins_float, osc_wd_en, wdt_start;
  logic grant_pd, grant_idle, grant_slow;

  int tests = 0, fails = 0, starts = 0;
  int stb_div = 0;
  bit done = 0;

  always #5 clk = ~clk;

  always @(negedge clk) begin
    mc_stb  <= (stb_div == 11);
    stb_div <= (stb_div == 11) ? 0 : stb_div + 1;
  end

  always @(posedge clk) if (wdt_start) starts++;

  rpd_ctrl dut_i (
    .clk(clk), .por_n(por_n), .mc_stb(mc_stb),
    .rst_pin_n(rst_pin_n), .pd_pin_n(pd_pin_n), .pe_swd_pin(pe_swd_pin),
    .owe_pin(owe_pin), .wdt_timeout(wdt_timeout), .osc_fail(osc_fail),
    .sw_pd_req(sw_pd_req), .sw_idle_req(sw_idle_req), .sw_slow_req(sw_slow_req),
    .rst_req(rst_req), .rst_out_n(rst_out_n), .pins_float(pins_float),
    .osc_wd_en(osc_wd_en), .wdt_start(wdt_start),
    .grant_pd(grant_pd), .grant_idle(grant_idle), .grant_slow(grant_slow)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_stb(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      while (!mc_stb) @(posedge clk);
    end
  endtask

  task automatic clks(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic recover();
    wait_stb(HOLD + 3);
    clks(2);
  endtask

  // {pin select (0 rst,1 pd), strobes low, expect reset, expect float}
  localparam logic [6:0] VEC [0:5] = '{
    {1'b0, 4'd1, 1'b0, 1'b0},
    {1'b0, 4'd2, 1'b1, 1'b0},
    {1'b0, 4'd6, 1'b1, 1'b0},
    {1'b1, 4'd1, 1'b0, 1'b0},
    {1'b1, 4'd3, 1'b1, 1'b0},
    {1'b1, 4'd5, 1'b1, 1'b1}
  };

  initial begin
    // R9 power-on state
    clks(3);
    check(rst_out_n == 1'b0, "R9", rst_out_n, 0);
    check(pins_float == 1'b0, "R9", pins_float, 0);
    por_n = 1'b1;
    wait_stb(2); clks(2);
    check(rst_out_n == 1'b0, "R9", rst_out_n, 0);
    wait_stb(1); clks(2);
    check(rst_out_n == 1'b1, "R9", rst_out_n, 1);

    // table walk: R1 reset pin, R2/R3 power-down pin
    for (int v = 0; v < 6; v++) begin
      wait_stb(1); @(negedge clk);
      if (VEC[v][6]) pd_pin_n = 1'b0; else rst_pin_n = 1'b0;
      wait_stb(int'(VEC[v][5:2])); clks(2);
      check(rst_out_n == !VEC[v][1], VEC[v][6] ? "R2" : "R1", rst_out_n, !VEC[v][1]);
      check(pins_float == VEC[v][0], "R3", pins_float, VEC[v][0]);
      rst_pin_n = 1'b1; pd_pin_n = 1'b1;
      recover();
      check(rst_out_n == 1'b1, "R4", rst_out_n, 1);
    end

    // R4 stretch after reset pin release
    wait_stb(1); @(negedge clk); rst_pin_n = 1'b0;
    wait_stb(3); @(negedge clk); rst_pin_n = 1'b1;
    wait_stb(2); clks(2);
    check(rst_out_n == 1'b0, "R4", rst_out_n, 0);
    wait_stb(1); clks(2);
    check(rst_out_n == 1'b1, "R4", rst_out_n, 1);

    // R3/R4 power-down exit issues a reset
    wait_stb(1); @(negedge clk); pd_pin_n = 1'b0;
    wait_stb(5); clks(2);
    check(pins_float == 1'b1, "R3", pins_float, 1);
    @(negedge clk); pd_pin_n = 1'b1;
    clks(4);
    check(pins_float == 1'b0, "R3", pins_float, 0);
    check(rst_out_n == 1'b0, "R4", rst_out_n, 0);
    recover();
    check(rst_out_n == 1'b1, "R4", rst_out_n, 1);

    // R5 watchdog timeout
    @(negedge clk); wdt_timeout = 1'b1;
    @(negedge clk); wdt_timeout = 1'b0;
    @(negedge clk);
    check(rst_out_n == 1'b0, "R5", rst_out_n, 0);
    recover();

    // R6 oscillator watchdog gating
    owe_pin = 1'b0; clks(4);
    check(osc_wd_en == 1'b0, "R6", osc_wd_en, 0);
    @(negedge clk); osc_fail = 1'b1;
    @(negedge clk); osc_fail = 1'b0;
    clks(1);
    check(rst_out_n == 1'b1, "R6", rst_out_n, 1);
    owe_pin = 1'b1; clks(4);
    check(osc_wd_en == 1'b1, "R6", osc_wd_en, 1);
    @(negedge clk); osc_fail = 1'b1;
    @(negedge clk); osc_fail = 1'b0;
    clks(1);
    check(rst_out_n == 1'b0, "R6", rst_out_n, 0);
    recover();

    // R7 power-mode gating
    pe_swd_pin = 1'b0; clks(4);
    sw_pd_req = 1'b1; sw_idle_req = 1'b1; sw_slow_req = 1'b1; #1;
    check({grant_pd, grant_idle, grant_slow} == 3'b111, "R7",
          {grant_pd, grant_idle, grant_slow}, 7);
    pe_swd_pin = 1'b1; clks(4); #1;
    check({grant_pd, grant_idle, grant_slow} == 3'b000, "R7",
          {grant_pd, grant_idle, grant_slow}, 0);
    sw_pd_req = 1'b0; sw_idle_req = 1'b0; sw_slow_req = 1'b0;

    // R8 watchdog auto-start select
    begin
      int base;
      base = starts;
      @(negedge clk); wdt_timeout = 1'b1;
      @(negedge clk); wdt_timeout = 1'b0;
      recover();
      check(starts - base == 1, "R8", starts - base, 1);
      pe_swd_pin = 1'b0; clks(4);
      base = starts;
      @(negedge clk); wdt_timeout = 1'b1;
      @(negedge clk); wdt_timeout = 1'b0;
      recover();
      check(starts - base == 0, "R8", starts - base, 0);
    end

    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    #(1_000_000);
    if (!done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule